// File: doc/BRIEF.md
# Dual Down-Counting Timer on an APB Slave

The block places two identical down-counting timers behind a single APB slave port. Each timer has its own group of registers: a reload value, the live count, a control word, an interrupt acknowledge, raw and masked interrupt status, and a second reload register that does not disturb the running count. Software picks the counter width (16 or 32 bits), a clock divider (1, 16 or 256), and one of three behaviours when the count reaches zero. In free-run mode the counter wraps to all ones. In periodic mode it reloads. In one-shot mode it stops.

The counters run on the APB clock, so no clock-domain crossing is needed. Each timer drives its own interrupt line. That line is high while the timer's raw flag is set and its interrupt enable is on. There is no combined interrupt output.

Top module: `apb_dual_timer`

## Requirements
- R1: Address bit 5 selects the timer (0 for the first, 1 for the second). Bits [4:2] select the register: 0 reload+count, 1 count, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 reload only. Accesses to one timer never change the other.
- R2: After reset every register of both timers reads 0 and both interrupt lines are low.
- R3: Control bits are: 7 enable, 6 periodic, 5 interrupt enable, [3:2] divider, 1 32-bit width, 0 one-shot. The control register reads back what was written in these bits, and reads 0 in bit 4 and in bits above 7.
- R4: While the timer is enabled, the count drops by one on each divided tick. The divider is set by bits [3:2]: code 0 divides by 1, code 1 by 16, and codes 2 and 3 by 256. The first decrement comes 1, 16 or 256 cycles after the control write that enables the timer.
- R5: The raw status bit is set when a decrement brings the active count to 0.
- R6: In free-run mode (periodic bit 0, one-shot bit 0), the tick after the count reaches 0 loads all ones of the selected width: 0xFFFF or 0xFFFFFFFF.
- R7: In periodic mode, the tick after the count reaches 0 loads the reload value.
- R8: In one-shot mode the count stays at 0 after it fires, until the reload+count register is written again.
- R9: In 16-bit mode, only bits [15:0] are counted and tested for zero, and the count register reads those bits zero-extended.
- R10: A write to reload+count sets both the reload value and the count, and restarts the divider. A write to reload-only changes only the reload value. Writes to the count register are ignored.
- R11: Any write to interrupt clear clears the raw flag. If the flag is set in the same cycle, the set wins.
- R12: The masked status equals the raw flag AND the interrupt enable, and each interrupt output equals its timer's masked status.
- R13: Clearing the enable bit freezes the count at its present value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock, also the counting clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high with pwrite low |
| irq | output | 2 | Per-timer interrupt, bit 0 for the first timer |

## Verification
The counting function is tried with several patterns, each chosen to tell apart a pair of behaviours. Short loads in each mode separate wrap from reload from halt. A 16-bit count whose upper half is nonzero shows whether zero detection ignores those upper bits. Reload-only writes made mid-count show that the live value is left alone and that only the next period changes. Divider settings are confirmed by sampling one cycle before and one cycle after the expected tick. A clear write timed to land on the very tick that sets the flag shows which of the two wins.

// File: rtl/apb_dual_timer.sv
module apb_dual_timer #(
  parameter int ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic [1:0]        irq
);
  localparam logic [2:0] A_LOAD = 3'd0, A_VAL = 3'd1, A_CTRL = 3'd2, A_CLR = 3'd3,
                         A_RIS = 3'd4, A_MIS = 3'd5, A_BG = 3'd6;

  logic [31:0] load_q [2];
  logic [31:0] cnt_q  [2];
  logic [7:0]  div_q  [2];
  logic [1:0]  pre_q  [2];
  logic        en_q   [2];
  logic        per_q  [2];
  logic        ie_q   [2];
  logic        wide_q [2];
  logic        os_q   [2];
  logic        ris_q  [2];
  logic [31:0] rd_t   [2];

  wire       wr_stb = psel & penable & pwrite;
  wire       in_map = (paddr[ADDR_W-1:6] == '0);
  wire       t_sel  = paddr[5];
  wire [2:0] r_sel  = paddr[4:2];

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    wire hit    = wr_stb & in_map & (t_sel == g[0]);
    wire w_load = hit & (r_sel == A_LOAD);
    wire w_ctrl = hit & (r_sel == A_CTRL);
    wire w_clr  = hit & (r_sel == A_CLR);
    wire w_bg   = hit & (r_sel == A_BG);

    wire [31:0] vis  = wide_q[g] ? cnt_q[g] : {16'h0, cnt_q[g][15:0]};
    wire        zero = (vis == 32'd0);
    wire        tick = en_q[g] & ((pre_q[g] == 2'd0) |
                                  (pre_q[g] == 2'd1 && div_q[g][3:0] == 4'hF) |
                                  (pre_q[g][1] && div_q[g] == 8'hFF));
    wire        fire = tick & ~w_load & (vis == 32'd1);

    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        load_q[g] <= '0;
        cnt_q[g]  <= '0;
        div_q[g]  <= '0;
        pre_q[g]  <= '0;
        en_q[g]   <= 1'b0;
        per_q[g]  <= 1'b0;
        ie_q[g]   <= 1'b0;
        wide_q[g] <= 1'b0;
        os_q[g]   <= 1'b0;
        ris_q[g]  <= 1'b0;
      end else begin
        if (w_ctrl) begin
          en_q[g]   <= pwdata[7];
          per_q[g]  <= pwdata[6];
          ie_q[g]   <= pwdata[5];
          pre_q[g]  <= pwdata[3:2];
          wide_q[g] <= pwdata[1];
          os_q[g]   <= pwdata[0];
        end
        if (w_load | w_bg) load_q[g] <= pwdata;
        if (w_load | ~en_q[g]) div_q[g] <= '0;
        else                   div_q[g] <= div_q[g] + 8'd1;
        if (w_load)
          cnt_q[g] <= pwdata;
        else if (tick) begin
          if (!zero)          cnt_q[g] <= cnt_q[g] - 32'd1;
          else if (os_q[g])   cnt_q[g] <= cnt_q[g];
          else if (per_q[g])  cnt_q[g] <= load_q[g];
          else if (wide_q[g]) cnt_q[g] <= '1;
          else                cnt_q[g] <= {cnt_q[g][31:16], 16'hFFFF};
        end
        if (fire)       ris_q[g] <= 1'b1;
        else if (w_clr) ris_q[g] <= 1'b0;
      end
    end

    assign irq[g] = ris_q[g] & ie_q[g];

    always_comb begin
      case (r_sel)
        A_LOAD, A_BG: rd_t[g] = load_q[g];
        A_VAL:        rd_t[g] = vis;
        A_CTRL:       rd_t[g] = {24'h0, en_q[g], per_q[g], ie_q[g], 1'b0,
                                 pre_q[g], wide_q[g], os_q[g]};
        A_RIS:        rd_t[g] = {31'h0, ris_q[g]};
        A_MIS:        rd_t[g] = {31'h0, irq[g]};
        default:      rd_t[g] = '0;
      endcase
    end
  end

  assign prdata = (psel & ~pwrite & in_map) ? rd_t[t_sel] : 32'h0;
endmodule

// File: rtl/apb_dual_timer_chk.sv
module apb_dual_timer_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [1:0]        irq,
  input logic [31:0]       cnt_q [2],
  input logic              en_q  [2],
  input logic              os_q  [2],
  input logic              wide_q[2],
  input logic              ris_q [2]
);
  wire wr = psel & penable & pwrite & (paddr[ADDR_W-1:6] == '0);

  for (genvar g = 0; g < 2; g++) begin : g_chk
    wire        ld  = wr & (paddr[5] == g[0]) & (paddr[4:2] == 3'd0);
    wire        clr = wr & (paddr[5] == g[0]) & (paddr[4:2] == 3'd3);
    wire [31:0] vis = wide_q[g] ? cnt_q[g] : {16'h0, cnt_q[g][15:0]};

    p_hold_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[g] && !ld) |=> $stable(cnt_q[g]));
    p_rise_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ris_q[g]) |-> (vis == 32'd0));
    p_rise_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ris_q[g]) |-> $past(en_q[g]));
    p_oneshot_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[g] && os_q[g] && vis == 32'd0 && !ld) |=> $stable(cnt_q[g]));
    p_clear_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !en_q[g]) |=> !ris_q[g]);
    p_irq_needs_raw_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> ris_q[g]);
  end
endmodule

bind apb_dual_timer apb_dual_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .irq(irq), .cnt_q(cnt_q), .en_q(en_q), .os_q(os_q),
  .wide_q(wide_q), .ris_q(ris_q)
);

// File: tb/apb_dual_timer_test.sv
module apb_dual_timer_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0]  irq;
  int errors = 0, checks = 0;

  apb_dual_timer #(.ADDR_W(12)) uut (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    psel = 0;
  endtask

  task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) chk_rd("R2 reset reg", 12'(a * 4), 32'h0);
    chk("R2 reset irq", {30'h0, irq}, 32'h0);
  endtask

  task automatic t_free16;
    wr(12'h000, 32'd10);
    wr(12'h008, 32'hA0);
    chk_rd("R4 value at enable", 12'h004, 32'd10);
    step(4);
    chk_rd("R4 four ticks", 12'h004, 32'd6);
    chk_rd("R5 raw low early", 12'h010, 32'd0);
    step(6);
    chk_rd("R5 value zero", 12'h004, 32'd0);
    chk_rd("R5 raw set", 12'h010, 32'd1);
    chk("R12 irq0 high", {30'h0, irq}, 32'd1);
    chk_rd("R1 other timer raw", 12'h030, 32'd0);
    step(1);
    chk_rd("R6 wrap 16-bit", 12'h004, 32'h0000FFFF);
    wr(12'h00C, 32'h0);
    chk_rd("R11 clear raw", 12'h010, 32'd0);
    chk("R12 irq0 low after clear", {30'h0, irq}, 32'd0);
    chk_rd("R11 count during clear", 12'h004, 32'h0000FFFD);
    wr(12'h008, 32'h0);
    chk_rd("R13 stop value", 12'h004, 32'h0000FFFB);
    step(5);
    chk_rd("R13 frozen", 12'h004, 32'h0000FFFB);
  endtask

  task automatic t_periodic16;
    wr(12'h020, 32'd3);
    wr(12'h028, 32'hE4);
    step(15);
    chk_rd("R4 div16 before tick", 12'h024, 32'd3);
    step(1);
    chk_rd("R4 div16 first tick", 12'h024, 32'd2);
    step(32);
    chk_rd("R5 timer2 zero", 12'h024, 32'd0);
    chk_rd("R5 timer2 raw", 12'h030, 32'd1);
    chk("R1 irq1 only", {30'h0, irq}, 32'd2);
    step(16);
    chk_rd("R7 periodic reload", 12'h024, 32'd3);
    wr(12'h028, 32'h0);
    wr(12'h02C, 32'h0);
  endtask

  task automatic t_div256(input logic [11:0] base, input logic [31:0] ctl, input string tag);
    wr(base, 32'd2);
    wr(base + 12'h008, ctl);
    step(255);
    chk_rd({tag, " before tick"}, base + 12'h004, 32'd2);
    step(1);
    chk_rd({tag, " first tick"}, base + 12'h004, 32'd1);
    wr(base + 12'h008, 32'h0);
  endtask

  task automatic t_oneshot;
    wr(12'h000, 32'd3);
    wr(12'h008, 32'hA3);
    step(3);
    chk_rd("R8 reaches zero", 12'h004, 32'd0);
    chk_rd("R8 raw set", 12'h010, 32'd1);
    step(5);
    chk_rd("R8 halted", 12'h004, 32'd0);
    wr(12'h000, 32'd2);
    chk_rd("R10 load restarts", 12'h004, 32'd2);
    wr(12'h00C, 32'h0);
    chk_rd("R11 set wins over clear", 12'h010, 32'd1);
    wr(12'h00C, 32'h0);
    chk_rd("R11 second clear", 12'h010, 32'd0);
    wr(12'h008, 32'h0);
  endtask

  task automatic t_wrap32;
    wr(12'h020, 32'd2);
    wr(12'h028, 32'h82);
    step(2);
    chk_rd("R5 32-bit zero", 12'h024, 32'd0);
    step(1);
    chk_rd("R6 wrap 32-bit", 12'h024, 32'hFFFFFFFF);
    wr(12'h028, 32'h0);
    wr(12'h02C, 32'h0);
  endtask

  task automatic t_mask16;
    wr(12'h000, 32'h00030002);
    chk_rd("R9 masked view", 12'h004, 32'd2);
    chk_rd("R10 reload read", 12'h000, 32'h00030002);
    wr(12'h008, 32'h80);
    step(2);
    chk_rd("R9 low-half zero", 12'h004, 32'd0);
    chk_rd("R9 raw on low zero", 12'h010, 32'd1);
    chk_rd("R12 masked off", 12'h014, 32'd0);
    chk("R12 irq0 off", {30'h0, irq}, 32'd0);
    step(1);
    chk_rd("R9 wrap low half", 12'h004, 32'h0000FFFF);
    wr(12'h008, 32'hA0);
    chk_rd("R12 masked on", 12'h014, 32'd1);
    chk("R12 irq0 on", {30'h0, irq}, 32'd1);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h0);
    chk_rd("R13 stopped", 12'h004, 32'h0000FFF9);
    wr(12'h004, 32'h1234);
    chk_rd("R10 value write ignored", 12'h004, 32'h0000FFF9);
  endtask

  task automatic t_bgload;
    wr(12'h020, 32'd5);
    wr(12'h028, 32'hE0);
    chk_rd("R7 start", 12'h024, 32'd5);
    wr(12'h038, 32'd2);
    chk_rd("R10 bg keeps count", 12'h024, 32'd3);
    chk_rd("R10 bg reload", 12'h020, 32'd2);
    step(3);
    chk_rd("R7 bg zero", 12'h024, 32'd0);
    step(1);
    chk_rd("R7 bg reload used", 12'h024, 32'd2);
    wr(12'h028, 32'h0);
    wr(12'h02C, 32'h0);
  endtask

  task automatic t_ctrl;
    wr(12'h028, 32'hFFFF_FF7F);
    chk_rd("R3 readback", 12'h028, 32'h0000006F);
    chk_rd("R1 timer1 ctrl untouched", 12'h008, 32'h0);
    wr(12'h028, 32'h0);
  endtask

  initial begin
    fork
      begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_free16();
        t_periodic16();
        t_div256(12'h000, 32'h88, "R4 div256 code2");
        t_div256(12'h020, 32'h8C, "R4 div256 code3");
        t_oneshot();
        t_wrap32();
        t_mask16();
        t_bgload();
        t_ctrl();
      end
      begin
        step(20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule